// File: doc/BRIEF.md
# SPI Digital-Potentiometer Command Front End

This block is the serial slave side of a single 64-position digital potentiometer controller. A host frames each command with an active-low chip select. The first byte names the device: a fixed type code plus one bit that must agree with a board strap pin. The second byte carries a four-bit operation code and a two-bit pointer to one of four stored settings. Depending on the operation, the frame then ends, carries a third data byte in either direction, or continues as an open-ended run of single-step wiper moves, one per clock pulse.

The serial pins are oversampled in the system clock domain. Every change the block wants made to the wiper register or the stored settings leaves it as a request on a valid/ready channel to a separate register-bank block. The bank owns the storage, the saturation of the wiper at its ends and the nonvolatile timing. For reads, the bank presents the current wiper value, the setting chosen by `dreg_sel`, and a write-busy flag. The block shifts these out on the serial output.

Back-pressure: a request stays on `req_*` with all fields frozen until the bank raises `req_ready` in a cycle where `req_valid` is high. A new event that comes in while a request is still waiting is discarded. The bank is expected to accept within one SCK period.

Top module: `dpot_spi_frontend`

## Requirements
- R1: The first byte after `cs_n` falls is taken MSB first. Its bits [7:4] must be 0101, bits [3:1] must be 110, and bit 0 must equal `addr_strap`. If any of these differ, the rest of the frame produces no request and no serial output until `cs_n` rises.
- R2: The second byte is decoded as opcode in bits [7:4] and pointer in bits [3:2]. Bits [1:0] must be 00, except for the status read. The opcodes are: 1001 read wiper, 1010 write wiper, 1011 read setting, 1100 write setting, 1101 copy setting to wiper, 1110 copy wiper to setting, 0010 step mode, and the full byte 01010001 for status. For the wiper operations and step mode, the pointer bits must also be 00. Any other byte causes no request.
- R3: A wiper write takes a third byte laid out as 0 0 D5..D0. When its eighth bit is sampled, the block issues `req_kind`=1 with `req_data`=D5..D0. If bits [7:6] are not 00, no request is issued.
- R4: SI is sampled on each SCK rising edge, and `so` changes only after SCK falling edges. For a read, the third byte appears MSB first. Its first bit follows the falling edge that closes the instruction byte. The byte is 0 0 plus the six data bits for the wiper or the selected setting, and seven zeros then `busy_in` for status.
- R5: A setting write (`req_kind`=2, `req_reg`=pointer) is issued only when `cs_n` rises, and only if a full third byte with bits [7:6]=00 was received. A frame cut short issues nothing.
- R6: The two copy commands issue their request as soon as the instruction byte is complete, without waiting for `cs_n`. Copying a setting to the wiper is `req_kind`=3, and copying the wiper to a setting is `req_kind`=4, with `req_reg` set to the pointer.
- R7: After the step opcode, each SCK rising edge issues one request until `cs_n` rises. It is `req_kind`=5 (toward the high end) when SI is 1, and `req_kind`=6 (toward the low end) when SI is 0.
- R8: While `hold_n` is low, SCK edges are ignored and the frame position is kept. When `hold_n` goes high again, the frame continues from where it stopped.
- R9: `so_oe` is low whenever `cs_n` is high. It is high only during the data byte of a read command.
- R10: After reset, nothing is decoded until a falling edge of `cs_n` has been seen.
- R11: While `req_valid` is high and `req_ready` is low, `req_kind`, `req_reg` and `req_data` hold their values. An event that arrives during that time is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the SCK rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Serial chip select, active low |
| sck | input | 1 | Serial clock |
| si | input | 1 | Serial data from host |
| hold_n | input | 1 | Pause input, active low |
| addr_strap | input | 1 | Board strap compared with the ID byte LSB |
| so | output | 1 | Serial data to host |
| so_oe | output | 1 | Output enable for the `so` driver |
| req_valid | output | 1 | Request to register bank is valid |
| req_ready | input | 1 | Register bank accepts the request |
| req_kind | output | 3 | Request code (1..6, see R3 to R7) |
| req_reg | output | 2 | Setting pointer of the request |
| req_data | output | 6 | Data of a write request |
| dreg_sel | output | 2 | Setting selected for read data |
| wiper_in | input | 6 | Current wiper value from bank |
| dreg_in | input | 6 | Setting selected by `dreg_sel` |
| busy_in | input | 1 | Bank write-busy flag for status reads |

## Verification
The properties assume the following about the inputs. SCK stays at or below a quarter of the system clock, so every edge survives the two-flop synchronisers as a separate event. SI is steady across each rising edge. `hold_n` changes only while SCK is low. The bank leaves `req_ready` low for less than one SCK period, except in a deliberate stall. The stimulus keeps to these limits as follows. It holds SCK for six system cycles in each phase. It changes SI and `hold_n` only in the low phase. It drops `req_ready` only in the one scenario that checks that fields stay frozen and that a second event is discarded.

// File: rtl/dpot_pkg.sv
package dpot_pkg;
  // request codes seen by the register bank
  typedef enum logic [2:0] {
    RQ_NONE          = 3'd0,
    RQ_WR_WIPER      = 3'd1,
    RQ_WR_DREG       = 3'd2,
    RQ_DREG_TO_WIPER = 3'd3,
    RQ_WIPER_TO_DREG = 3'd4,
    RQ_STEP_UP       = 3'd5,
    RQ_STEP_DN       = 3'd6
  } req_kind_e;

  typedef enum logic [3:0] {
    CMD_BAD, CMD_RD_WIPER, CMD_WR_WIPER, CMD_RD_DREG, CMD_WR_DREG,
    CMD_LD_WIPER, CMD_SV_WIPER, CMD_STEP, CMD_STATUS
  } cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ID, ST_INSTR, ST_DATA, ST_STEP, ST_DONE
  } fst_e;

  localparam logic [3:0] DEV_TYPE  = 4'b0101;
  localparam logic [2:0] DEV_FIXED = 3'b110;
endpackage

// File: rtl/dpot_sync_edge.sv
module dpot_sync_edge #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] pipe;
  logic              last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe <= {STAGES{RST_VAL}};
      last <= RST_VAL;
    end else begin
      pipe <= {pipe[STAGES-2:0], d};
      last <= pipe[STAGES-1];
    end
  end

  assign q    = pipe[STAGES-1];
  assign rise = q & ~last;
  assign fall = ~q & last;
endmodule

// File: rtl/dpot_cmd_decode.sv
module dpot_cmd_decode
  import dpot_pkg::*;
(
  input  logic [7:0] byte_in,
  input  logic       strap,
  output logic       id_ok,
  output cmd_e       cmd
);
  logic [3:0] op;
  logic [3:0] low;

  assign op  = byte_in[7:4];
  assign low = byte_in[3:0];

  assign id_ok = (byte_in[7:4] == DEV_TYPE) && (byte_in[3:1] == DEV_FIXED) &&
                 (byte_in[0] == strap);

  always_comb begin
    cmd = CMD_BAD;
    unique case (op)
      4'b1001: if (low == 4'b0000)       cmd = CMD_RD_WIPER;
      4'b1010: if (low == 4'b0000)       cmd = CMD_WR_WIPER;
      4'b1011: if (low[1:0] == 2'b00)    cmd = CMD_RD_DREG;
      4'b1100: if (low[1:0] == 2'b00)    cmd = CMD_WR_DREG;
      4'b1101: if (low[1:0] == 2'b00)    cmd = CMD_LD_WIPER;
      4'b1110: if (low[1:0] == 2'b00)    cmd = CMD_SV_WIPER;
      4'b0010: if (low == 4'b0000)       cmd = CMD_STEP;
      4'b0101: if (low == 4'b0001)       cmd = CMD_STATUS;
      default: cmd = CMD_BAD;
    endcase
  end
endmodule

// File: rtl/dpot_so_shift.sv
module dpot_so_shift #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         load,
  input  logic         shift,
  input  logic [W-1:0] din,
  output logic         so
);
  logic [W-1:0] sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sr <= '0;
    else if (clr)   sr <= '0;
    else if (load)  sr <= din;
    else if (shift) sr <= {sr[W-2:0], 1'b0};
  end

  assign so = sr[W-1];
endmodule

// File: rtl/dpot_spi_frontend.sv
module dpot_spi_frontend
  import dpot_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DATA_W      = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sck,
  input  logic              si,
  input  logic              hold_n,
  input  logic              addr_strap,
  output logic              so,
  output logic              so_oe,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [2:0]        req_kind,
  output logic [1:0]        req_reg,
  output logic [DATA_W-1:0] req_data,
  output logic [1:0]        dreg_sel,
  input  logic [DATA_W-1:0] wiper_in,
  input  logic [DATA_W-1:0] dreg_in,
  input  logic              busy_in
);
  localparam int BYTE_W = 8;
  localparam int PAD_W  = BYTE_W - DATA_W;
  localparam int CNT_W  = 5;
  localparam logic [CNT_W-1:0] ID_END    = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] INSTR_END = CNT_W'(2*BYTE_W - 1);
  localparam logic [CNT_W-1:0] RD_FIRST  = CNT_W'(2*BYTE_W);
  localparam logic [CNT_W-1:0] DATA_END  = CNT_W'(3*BYTE_W - 1);
  localparam logic [CNT_W-1:0] CNT_SAT   = CNT_W'(3*BYTE_W);
  localparam int NSYNC = 4;
  // index: 0 sck, 1 si, 2 cs_n, 3 hold_n
  localparam logic [NSYNC-1:0] SYNC_RST = 4'b1000;

  // ---------------- input synchronisation ----------------
  logic [NSYNC-1:0] raw_in, s_q, s_rise, s_fall;
  assign raw_in = {hold_n, cs_n, si, sck};

  for (genvar g = 0; g < NSYNC; g++) begin : g_sync
    dpot_sync_edge #(.STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST[g])) u_sync (
      .clk (clk), .rst_n(rst_n), .d(raw_in[g]),
      .q   (s_q[g]), .rise(s_rise[g]), .fall(s_fall[g])
    );
  end

  logic si_s, cs_s, hold_s, cs_fall, cs_rise, sck_rise, sck_fall;
  assign si_s     = s_q[1];
  assign cs_s     = s_q[2];
  assign hold_s   = s_q[3];
  assign cs_fall  = s_fall[2];
  assign cs_rise  = s_rise[2];
  assign sck_rise = s_rise[0] & ~cs_s & hold_s;
  assign sck_fall = s_fall[0] & ~cs_s & hold_s;

  // ---------------- frame state ----------------
  fst_e                state;
  logic [CNT_W-1:0]    bit_cnt;
  logic [BYTE_W-1:0]   shift_in, nxt_byte;
  cmd_e                cmd_q, dec_cmd;
  logic [1:0]          ptr_q;
  logic                rd_active, wr_armed, id_ok;
  logic [DATA_W-1:0]   data_hold;

  assign nxt_byte = {shift_in[BYTE_W-2:0], si_s};

  dpot_cmd_decode u_dec (
    .byte_in(nxt_byte), .strap(addr_strap), .id_ok(id_ok), .cmd(dec_cmd)
  );

  logic is_rd, so_load, so_shift;
  logic [BYTE_W-1:0] rd_val;

  assign is_rd    = (cmd_q == CMD_RD_WIPER) || (cmd_q == CMD_RD_DREG) ||
                    (cmd_q == CMD_STATUS);
  assign so_load  = sck_fall && (state == ST_DATA) && is_rd && (bit_cnt == RD_FIRST);
  assign so_shift = sck_fall && rd_active && (bit_cnt > RD_FIRST) && (bit_cnt <= DATA_END);

  always_comb begin
    unique case (cmd_q)
      CMD_RD_WIPER: rd_val = {{PAD_W{1'b0}}, wiper_in};
      CMD_RD_DREG:  rd_val = {{PAD_W{1'b0}}, dreg_in};
      CMD_STATUS:   rd_val = {{(BYTE_W-1){1'b0}}, busy_in};
      default:      rd_val = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      bit_cnt   <= '0;
      shift_in  <= '0;
      cmd_q     <= CMD_BAD;
      ptr_q     <= '0;
      rd_active <= 1'b0;
      wr_armed  <= 1'b0;
      data_hold <= '0;
    end else if (cs_fall) begin
      state     <= ST_ID;
      bit_cnt   <= '0;
      cmd_q     <= CMD_BAD;
      rd_active <= 1'b0;
      wr_armed  <= 1'b0;
    end else if (cs_rise) begin
      state     <= ST_IDLE;
      rd_active <= 1'b0;
      wr_armed  <= 1'b0;
    end else begin
      if (so_load) rd_active <= 1'b1;
      if (sck_rise) begin
        shift_in <= nxt_byte;
        if (bit_cnt != CNT_SAT) bit_cnt <= bit_cnt + 1'b1;
        unique case (state)
          ST_ID: if (bit_cnt == ID_END) state <= id_ok ? ST_INSTR : ST_DONE;
          ST_INSTR: if (bit_cnt == INSTR_END) begin
            cmd_q <= dec_cmd;
            ptr_q <= nxt_byte[3:2];
            unique case (dec_cmd)
              CMD_BAD, CMD_LD_WIPER, CMD_SV_WIPER: state <= ST_DONE;
              CMD_STEP:                            state <= ST_STEP;
              default:                             state <= ST_DATA;
            endcase
          end
          ST_DATA: if (bit_cnt == DATA_END) begin
            state <= ST_DONE;
            if (cmd_q == CMD_WR_DREG && nxt_byte[7:6] == 2'b00) begin
              wr_armed  <= 1'b1;
              data_hold <= nxt_byte[DATA_W-1:0];
            end
          end
          default: ;
        endcase
      end
    end
  end

  // ---------------- request generation ----------------
  logic              issue;
  req_kind_e         iss_kind;
  logic [1:0]        iss_reg;
  logic [DATA_W-1:0] iss_data;

  always_comb begin
    issue    = 1'b0;
    iss_kind = RQ_NONE;
    iss_reg  = ptr_q;
    iss_data = '0;
    if (cs_rise && wr_armed) begin
      issue    = 1'b1;
      iss_kind = RQ_WR_DREG;
      iss_data = data_hold;
    end else if (sck_rise) begin
      if (state == ST_INSTR && bit_cnt == INSTR_END &&
          (dec_cmd == CMD_LD_WIPER || dec_cmd == CMD_SV_WIPER)) begin
        issue    = 1'b1;
        iss_kind = (dec_cmd == CMD_LD_WIPER) ? RQ_DREG_TO_WIPER : RQ_WIPER_TO_DREG;
        iss_reg  = nxt_byte[3:2];
      end else if (state == ST_DATA && bit_cnt == DATA_END &&
                   cmd_q == CMD_WR_WIPER && nxt_byte[7:6] == 2'b00) begin
        issue    = 1'b1;
        iss_kind = RQ_WR_WIPER;
        iss_data = nxt_byte[DATA_W-1:0];
      end else if (state == ST_STEP) begin
        issue    = 1'b1;
        iss_kind = si_s ? RQ_STEP_UP : RQ_STEP_DN;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_valid <= 1'b0;
      req_kind  <= RQ_NONE;
      req_reg   <= '0;
      req_data  <= '0;
    end else if (issue && (!req_valid || req_ready)) begin
      req_valid <= 1'b1;
      req_kind  <= iss_kind;
      req_reg   <= iss_reg;
      req_data  <= iss_data;
    end else if (req_ready) begin
      req_valid <= 1'b0;
    end
  end

  // ---------------- serial output ----------------
  dpot_so_shift #(.W(BYTE_W)) u_so (
    .clk(clk), .rst_n(rst_n), .clr(cs_fall), .load(so_load),
    .shift(so_shift), .din(rd_val), .so(so)
  );

  assign so_oe    = rd_active & ~cs_s;
  assign dreg_sel = ptr_q;
endmodule

// File: rtl/dpot_spi_checker.sv
module dpot_spi_checker #(
  parameter int DATA_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_fall,
  input logic              cs_rise,
  input logic              sck_fall,
  input logic              hold_s,
  input logic [4:0]        bit_cnt,
  input logic              so,
  input logic              so_oe,
  input logic              is_rd,
  input logic              req_valid,
  input logic              req_ready,
  input logic [2:0]        req_kind,
  input logic [1:0]        req_reg,
  input logic [DATA_W-1:0] req_data
);
  p_kind_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_kind >= 3'd1 && req_kind <= 3'd6));

  p_so_moves_on_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!sck_fall && !cs_fall) |=> $stable(so));

  p_dreg_write_at_cs_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(req_valid) && req_kind == 3'd2) |-> $past(cs_rise));

  p_hold_freezes_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_s && !cs_fall) |=> $stable(bit_cnt));

  p_oe_only_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    so_oe |-> is_rd);

  p_req_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=>
      (req_valid && $stable(req_kind) && $stable(req_reg) && $stable(req_data)));
endmodule

bind dpot_spi_frontend dpot_spi_checker #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cs_fall  (cs_fall),
  .cs_rise  (cs_rise),
  .sck_fall (sck_fall),
  .hold_s   (hold_s),
  .bit_cnt  (bit_cnt),
  .so       (so),
  .so_oe    (so_oe),
  .is_rd    (is_rd),
  .req_valid(req_valid),
  .req_ready(req_ready),
  .req_kind (req_kind),
  .req_reg  (req_reg),
  .req_data (req_data)
);

// File: tb/sim_dpot_spi_frontend.sv
`timescale 1ns/1ps
module sim_dpot_spi_frontend;
  localparam int HALF = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b0, sck = 1'b0, si = 1'b0, hold_n = 1'b1, addr_strap = 1'b0;
  logic so, so_oe, req_valid, busy_in = 1'b0;
  logic req_ready = 1'b1;
  logic [2:0] req_kind;
  logic [1:0] req_reg, dreg_sel;
  logic [5:0] req_data, wiper_in, dreg_in;

  logic [5:0] m_wiper = 6'd0;
  logic [5:0] m_dr [4] = '{6'd0, 6'd0, 6'd0, 6'd0};
  int req_count = 0;
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  dpot_spi_frontend u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si), .hold_n(hold_n),
    .addr_strap(addr_strap), .so(so), .so_oe(so_oe), .req_valid(req_valid),
    .req_ready(req_ready), .req_kind(req_kind), .req_reg(req_reg), .req_data(req_data),
    .dreg_sel(dreg_sel), .wiper_in(wiper_in), .dreg_in(dreg_in), .busy_in(busy_in)
  );

  assign wiper_in = m_wiper;
  assign dreg_in  = m_dr[dreg_sel];

  // register bank model
  always @(posedge clk) begin
    if (rst_n && req_valid && req_ready) begin
      req_count <= req_count + 1;
      case (req_kind)
        3'd1: m_wiper <= req_data;
        3'd2: m_dr[req_reg] <= req_data;
        3'd3: m_wiper <= m_dr[req_reg];
        3'd4: m_dr[req_reg] <= m_wiper;
        3'd5: m_wiper <= (m_wiper == 6'd63) ? 6'd63 : m_wiper + 6'd1;
        3'd6: m_wiper <= (m_wiper == 6'd0) ? 6'd0 : m_wiper - 6'd1;
        default: ;
      endcase
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic sbit(input logic b, output logic r);
    si = b;
    repeat (HALF) @(negedge clk);
    r = so;
    sck = 1'b1;
    repeat (HALF) @(negedge clk);
    sck = 1'b0;
  endtask

  task automatic xbyte(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      logic r;
      sbit(tx[i], r);
      rx[i] = r;
    end
  endtask

  task automatic cs_low();
    @(negedge clk) cs_n = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic cs_high();
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    repeat (10) @(negedge clk);
  endtask

  function automatic logic [7:0] idb(input logic s);
    return {4'b0101, 3'b110, s};
  endfunction

  task automatic frame3(input logic [7:0] id, input logic [7:0] ins,
                        input logic [7:0] dat, output logic [7:0] rx);
    logic [7:0] junk;
    cs_low();
    xbyte(id, junk);
    xbyte(ins, junk);
    xbyte(dat, rx);
    cs_high();
  endtask

  task automatic frame2(input logic [7:0] id, input logic [7:0] ins);
    logic [7:0] junk;
    cs_low();
    xbyte(id, junk);
    xbyte(ins, junk);
    cs_high();
  endtask

  task automatic rd_wiper(output logic [7:0] v);
    frame3(idb(addr_strap), 8'h90, 8'h00, v);
  endtask

  initial begin
    logic [7:0] rx, junk;
    int base;
    // R10: chip select already low at reset
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("reset so_oe", int'(so_oe), 0);
    chk("reset req_valid", int'(req_valid), 0);
    xbyte(idb(1'b0), junk); xbyte(8'hA0, junk); xbyte(8'h11, junk);
    repeat (10) @(negedge clk);
    chk("R10 no decode before cs fall", req_count, 0);
    cs_high();

    // R3 R4: exhaustive wiper write then read-back
    for (int v = 0; v < 64; v++) begin
      frame3(idb(1'b0), 8'hA0, 8'(v), junk);
      rd_wiper(rx);
      chk("R3/R4 wiper readback", int'(rx), v);
    end

    // R5: setting writes commit only at cs rise
    for (int r = 0; r < 4; r++) begin
      logic [5:0] val;
      val = 6'((r * 21 + 5) % 64);
      base = req_count;
      cs_low();
      xbyte(idb(1'b0), junk); xbyte(8'hC0 | 8'(r << 2), junk); xbyte({2'b00, val}, junk);
      repeat (10) @(negedge clk);
      chk("R5 no commit before cs rise", req_count, base);
      cs_high();
      chk("R5 commit at cs rise", req_count, base + 1);
      frame3(idb(1'b0), 8'hB0 | 8'(r << 2), 8'h00, rx);
      chk("R4 setting readback", int'(rx), int'(val));
    end

    // R5: frame cut short
    base = req_count;
    cs_low();
    xbyte(idb(1'b0), junk); xbyte(8'hC4, junk);
    for (int i = 0; i < 4; i++) sbit(1'b0, junk[0]);
    cs_high();
    chk("R5 short frame no request", req_count, base);

    // R1: ID mismatch, both strap settings
    for (int s = 0; s < 2; s++) begin
      addr_strap = 1'(s);
      frame3(idb(1'(s)), 8'hA0, 8'h00, junk);
      base = req_count;
      frame3(idb(~1'(s)), 8'hA0, 8'h2A, junk);
      frame3(8'h4C | 8'(s), 8'hA0, 8'h2A, junk);
      frame3({4'b0101, 3'b111, 1'(s)}, 8'hA0, 8'h2A, junk);
      chk("R1 bad id no request", req_count, base);
      rd_wiper(rx);
      chk("R1 wiper untouched", int'(rx), 0);
    end
    addr_strap = 1'b0;

    // R2: unknown opcode and reserved bits
    base = req_count;
    frame3(idb(1'b0), 8'hF0, 8'h15, junk);
    frame3(idb(1'b0), 8'hA1, 8'h15, junk);
    frame3(idb(1'b0), 8'hA4, 8'h15, junk);
    frame2(idb(1'b0), 8'hD2);
    chk("R2 illegal instruction no request", req_count, base);
    // R3: reserved data bits
    frame3(idb(1'b0), 8'hA0, 8'h55, junk);
    chk("R3 reserved data bits no request", req_count, base);

    // R6: copies
    frame3(idb(1'b0), 8'hA0, 8'h2D, junk);
    base = req_count;
    cs_low();
    xbyte(idb(1'b0), junk); xbyte(8'hE8, junk);
    repeat (8) @(negedge clk);
    chk("R6 copy issued before cs rise", req_count, base + 1);
    cs_high();
    frame3(idb(1'b0), 8'hB8, 8'h00, rx);
    chk("R6 wiper to setting 2", int'(rx), 8'h2D);
    frame3(idb(1'b0), 8'hA0, 8'h07, junk);
    frame2(idb(1'b0), 8'hD8);
    rd_wiper(rx);
    chk("R6 setting 2 to wiper", int'(rx), 8'h2D);

    // R7: stepping
    frame3(idb(1'b0), 8'hA0, 8'd10, junk);
    base = req_count;
    cs_low();
    xbyte(idb(1'b0), junk); xbyte(8'h20, junk);
    for (int i = 0; i < 5; i++) sbit(1'b1, junk[0]);
    for (int i = 0; i < 2; i++) sbit(1'b0, junk[0]);
    cs_high();
    chk("R7 one request per pulse", req_count, base + 7);
    rd_wiper(rx);
    chk("R7 step direction", int'(rx), 13);

    // R4 R9: status and output enable
    busy_in = 1'b1;
    cs_low();
    xbyte(idb(1'b0), junk); xbyte(8'h51, junk); xbyte(8'h00, rx);
    chk("R4 status busy", int'(rx), 1);
    chk("R9 oe during read", int'(so_oe), 1);
    cs_high();
    chk("R9 oe off with cs high", int'(so_oe), 0);
    busy_in = 1'b0;
    frame3(idb(1'b0), 8'h51, 8'h00, rx);
    chk("R4 status idle", int'(rx), 0);
    cs_low();
    xbyte(idb(1'b0), junk); xbyte(8'hA0, junk); xbyte(8'h01, junk);
    chk("R9 oe off in write", int'(so_oe), 0);
    cs_high();

    // R8: hold pauses the frame
    cs_low();
    xbyte(idb(1'b0), junk); xbyte(8'hA0, junk);
    sbit(1'b0, junk[0]); sbit(1'b0, junk[0]); sbit(1'b1, junk[0]);
    hold_n = 1'b0;
    repeat (4) @(negedge clk);
    si = 1'b1;
    for (int i = 0; i < 4; i++) begin
      repeat (HALF) @(negedge clk); sck = 1'b1;
      repeat (HALF) @(negedge clk); sck = 1'b0;
    end
    repeat (4) @(negedge clk);
    hold_n = 1'b1;
    repeat (4) @(negedge clk);
    sbit(1'b1, junk[0]); sbit(1'b0, junk[0]); sbit(1'b0, junk[0]);
    sbit(1'b1, junk[0]); sbit(1'b1, junk[0]);
    cs_high();
    rd_wiper(rx);
    chk("R8 hold resumes frame", int'(rx), 8'h33);

    // R11: back-pressure
    req_ready = 1'b0;
    base = req_count;
    frame3(idb(1'b0), 8'hA0, 8'h15, junk);
    chk("R11 valid while stalled", int'(req_valid), 1);
    chk("R11 kind held", int'(req_kind), 1);
    frame3(idb(1'b0), 8'hA0, 8'h2A, junk);
    chk("R11 data held, later event dropped", int'(req_data), 8'h15);
    @(negedge clk) req_ready = 1'b1;
    repeat (4) @(negedge clk);
    chk("R11 one request accepted", req_count, base + 1);
    chk("R11 valid drops", int'(req_valid), 0);
    rd_wiper(rx);
    chk("R11 first value kept", int'(rx), 8'h15);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule